// File: doc/BRIEF.md
# Low-Side Pulse Stretcher with Overcurrent Window

This block sits between the PWM comparator and the low-side gate command of a synchronous buck controller. Current is sensed across the low-side switch while it conducts, so the block marks when that reading may be trusted. After each low-side turn-on it waits out a blanking interval. It then opens a monitor window that stays open until the low-side command falls. An overcurrent comparator hit that arrives inside the window is latched as a qualified trip. Hits outside the window are discarded.

At high duty cycle the low-side pulse can become too short to sample, or it can vanish. The block counts switching cycles that end without a pulse of at least the minimum width. In the third such cycle the pulse is held on until it reaches the minimum width. If that cycle has no pulse at all, a minimum-width pulse is inserted at the switching-cycle strobe that closes it. While a pulse is forced on past the PWM request, a high-side inhibit flag is raised so that both switches are never on together.

The controller is a four-state machine. OFF: low side off. BLANK: low side on, window still shut. WATCH: low side on at PWM request, window open. HOLD: low side forced on. The transitions are:
- OFF to BLANK on a request.
- OFF to HOLD on an insertion.
- BLANK to WATCH when the blanking count expires.
- BLANK or WATCH to HOLD when the request drops early in a stretch cycle.
- BLANK or WATCH to OFF when the request drops otherwise.
- HOLD to WATCH or OFF when the minimum width is reached, depending on whether the request is present again.

Top module: `lowside_pulse_guard`

## Requirements
- R1: While reset is held, and on the first clock after it, `lo_gate`, `hs_inhibit`, `mon_window` and `oc_trip` are all 0.
- R2: With no stretch or insertion in progress, `lo_gate` equals `pwm_lo_req` delayed by exactly one clock, so the pulse width is unchanged.
- R3: `mon_window` rises on the (BLANK_CYC+1)-th consecutive clock of `lo_gate` high, and never earlier within a pulse.
- R4: `mon_window` is 0 in every clock in which `lo_gate` is 0, so the window closes in the same clock the low-side command falls.
- R5: An `oc_raw` pulse while `mon_window` is 0 (during blanking or with the low side off) leaves `oc_trip` at 0.
- R6: `oc_raw` high in a clock with `mon_window` high sets `oc_trip` on the next clock. It then stays 1 until a clock in which `cyc_strobe` or `oc_ack` is high, and is 0 after that clock unless a new hit occurs.
- R7: A "narrow" cycle is the span between two `cyc_strobe` pulses in which no `lo_gate` pulse reaches MIN_CYC clocks. After two consecutive narrow cycles, a pulse in the third cycle stays on for exactly MIN_CYC clocks. `hs_inhibit` is 1 while it is held beyond the request.
- R8: If that third cycle has no pulse at all, the `cyc_strobe` closing it starts an inserted `lo_gate` pulse of exactly MIN_CYC clocks on the next clock. `hs_inhibit` is 1 for the whole inserted pulse.
- R9: A cycle containing a pulse of at least MIN_CYC clocks resets the narrow count to zero, so a narrow pulse that follows stays at its requested width.
- R10: A stretched or inserted pulse also resets the count, so under persistently narrow requests the forcing recurs every third cycle.
- R11: `hs_inhibit` is 1 only while `lo_gate` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_strobe | input | 1 | One-clock pulse marking the start of each switching cycle |
| pwm_lo_req | input | 1 | Low-side on request from the PWM comparator |
| oc_raw | input | 1 | Raw overcurrent comparator output |
| oc_ack | input | 1 | Sequencer acknowledge that clears the latched trip |
| lo_gate | output | 1 | Final low-side gate command |
| hs_inhibit | output | 1 | High-side turn-on must wait (low side forced on) |
| mon_window | output | 1 | Overcurrent monitor window open |
| oc_trip | output | 1 | Qualified, latched overcurrent trip |

## Verification
The hardest situation to reach is an insertion. It needs two narrow or empty cycles followed by a third cycle with no pulse at all. No single-cycle stimulus reaches it, and any wide pulse in between silently resets the count. The stimulus therefore runs whole switching cycles in a fixed sequence: wide cycles to clear the count, narrow runs to force a stretch twice in a row, three empty cycles to force an insertion at the closing strobe, then a narrow-wide-narrow-narrow run to show the reset. A behavioural model tracks the narrow count from the strobes alone and is compared with all four outputs on every clock.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

    // Low-side controller states
    typedef enum logic [1:0] {
        LS_OFF   = 2'd0,   // low side off
        LS_BLANK = 2'd1,   // low side on, sensing blanked
        LS_WATCH = 2'd2,   // low side on by request, window open
        LS_HOLD  = 2'd3    // low side forced on (stretch or insert)
    } ls_state_e;

    // Counter width able to hold values 0..n
    function automatic int unsigned span_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/lsp_on_timer.sv
// Counts clocks of low-side on-time and derives the blanking and
// minimum-width markers from that count.
module lsp_on_timer #(
    parameter int unsigned BLANK_CYC = 25,
    parameter int unsigned MIN_CYC   = 53
) (
    input  logic clk,
    input  logic rst_n,
    input  logic on_now,      // low side on in this clock
    input  logic on_next,     // low side on in the next clock
    output logic win_open,    // blanking over, pulse still on
    output logic blank_last,  // last blanked clock of the pulse
    output logic min_last,    // this clock completes MIN_CYC clocks
    output logic short_next   // next clock still below MIN_CYC
);
    localparam int unsigned CW = lsp_pkg::span_bits(MIN_CYC);
    localparam logic [CW-1:0] BLANK_V = CW'(BLANK_CYC);
    localparam logic [CW-1:0] BLANK_L = CW'(BLANK_CYC - 1);
    localparam logic [CW-1:0] MIN_V   = CW'(MIN_CYC);
    localparam logic [CW-1:0] MIN_L   = CW'(MIN_CYC - 1);

    logic [CW-1:0] on_cnt;

    // The count is zero in the first on-clock and saturates at MIN_CYC.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_cnt <= '0;
        end else if (!on_now || !on_next) begin
            on_cnt <= '0;
        end else if (on_cnt != MIN_V) begin
            on_cnt <= on_cnt + 1'b1;
        end
    end

    always_comb begin
        win_open   = on_now && (on_cnt >= BLANK_V);
        blank_last = (on_cnt == BLANK_L);
        min_last   = on_now && (on_cnt == MIN_L);
        short_next = (on_cnt < MIN_L);
    end

endmodule

// File: rtl/lsp_narrow_tracker.sv
// Tracks consecutive switching cycles that lack a full-width low-side
// pulse and arms the forcing logic for the cycle that completes the run.
module lsp_narrow_tracker #(
    parameter int unsigned RUN_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_strobe,
    input  logic lo_on,       // low side on in this clock
    input  logic min_last,    // a pulse reaches full width this clock
    output logic armed,       // this cycle must carry a full pulse
    output logic insert_now   // armed cycle closed with no pulse at all
);
    localparam int unsigned NW = lsp_pkg::span_bits(RUN_LEN);
    localparam logic [NW-1:0] ARM_V = NW'(RUN_LEN - 1);

    logic [NW-1:0] narrow_cnt;
    logic          wide_seen;
    logic          pulse_seen;

    always_comb begin
        armed      = (narrow_cnt == ARM_V);
        insert_now = cyc_strobe && armed && !pulse_seen && !lo_on;
    end

    // At each strobe the closing cycle is judged: a full pulse, or a
    // forced one in an armed cycle, restarts the run.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            narrow_cnt <= '0;
            wide_seen  <= 1'b0;
            pulse_seen <= 1'b0;
        end else if (cyc_strobe) begin
            narrow_cnt <= (wide_seen || armed) ? '0 : narrow_cnt + 1'b1;
            wide_seen  <= min_last;
            pulse_seen <= 1'b0;
        end else begin
            wide_seen  <= wide_seen || min_last;
            pulse_seen <= pulse_seen || lo_on;
        end
    end

endmodule

// File: rtl/lsp_trip_latch.sv
// Holds a qualified overcurrent hit until the cycle ends or it is acknowledged.
module lsp_trip_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic cyc_strobe,
    input  logic oc_ack,
    output logic trip
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trip <= 1'b0;
        end else if (hit) begin
            trip <= 1'b1;
        end else if (cyc_strobe || oc_ack) begin
            trip <= 1'b0;
        end
    end
endmodule

// File: rtl/lowside_pulse_guard.sv
// Low-side command conditioner: blanking, monitor window, and forcing of
// a minimum-width pulse in every third consecutive narrow cycle.
module lowside_pulse_guard #(
    parameter int unsigned BLANK_CYC = 25,
    parameter int unsigned MIN_CYC   = 53,
    parameter int unsigned RUN_LEN   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_strobe,
    input  logic pwm_lo_req,
    input  logic oc_raw,
    input  logic oc_ack,
    output logic lo_gate,
    output logic hs_inhibit,
    output logic mon_window,
    output logic oc_trip
);
    import lsp_pkg::*;

    ls_state_e state_q;
    ls_state_e state_d;
    logic      force_q;
    logic      force_d;

    logic win_open;
    logic blank_last;
    logic min_last;
    logic short_next;
    logic armed;
    logic insert_now;
    logic on_now;
    logic on_next;
    logic stretch_ok;
    logic oc_hit;

    assign on_now     = (state_q != LS_OFF);
    assign on_next    = (state_d != LS_OFF);
    assign stretch_ok = armed || force_q;

    lsp_on_timer #(
        .BLANK_CYC (BLANK_CYC),
        .MIN_CYC   (MIN_CYC)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .on_now     (on_now),
        .on_next    (on_next),
        .win_open   (win_open),
        .blank_last (blank_last),
        .min_last   (min_last),
        .short_next (short_next)
    );

    lsp_narrow_tracker #(
        .RUN_LEN (RUN_LEN)
    ) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_strobe (cyc_strobe),
        .lo_on      (on_now),
        .min_last   (min_last),
        .armed      (armed),
        .insert_now (insert_now)
    );

    lsp_trip_latch u_trip (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (oc_hit),
        .cyc_strobe (cyc_strobe),
        .oc_ack     (oc_ack),
        .trip       (oc_trip)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_OFF: begin
                if (pwm_lo_req) begin
                    state_d = LS_BLANK;
                end else if (insert_now) begin
                    state_d = LS_HOLD;
                end
            end
            LS_BLANK: begin
                if (!pwm_lo_req) begin
                    state_d = (stretch_ok && short_next) ? LS_HOLD : LS_OFF;
                end else if (blank_last) begin
                    state_d = LS_WATCH;
                end
            end
            LS_WATCH: begin
                if (!pwm_lo_req) begin
                    state_d = (stretch_ok && short_next) ? LS_HOLD : LS_OFF;
                end
            end
            LS_HOLD: begin
                if (!short_next) begin
                    state_d = pwm_lo_req ? LS_WATCH : LS_OFF;
                end
            end
            default: state_d = LS_OFF;
        endcase
    end

    // A pulse that starts in an armed cycle stays marked for stretching
    // even if the strobe in mid-pulse clears the run count.
    assign force_d = on_next ? (force_q || armed || insert_now) : 1'b0;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LS_OFF;
            force_q <= 1'b0;
        end else begin
            state_q <= state_d;
            force_q <= force_d;
        end
    end

    // Outputs
    always_comb begin
        lo_gate    = (state_q != LS_OFF);
        hs_inhibit = (state_q == LS_HOLD);
        mon_window = win_open;
        oc_hit     = win_open && oc_raw;
    end

endmodule

// File: rtl/lowside_pulse_guard_chk.sv
module lowside_pulse_guard_chk #(
    parameter int unsigned BLANK_CYC = 25,
    parameter int unsigned MIN_CYC   = 53
) (
    input logic clk,
    input logic rst_n,
    input logic cyc_strobe,
    input logic pwm_lo_req,
    input logic oc_raw,
    input logic oc_ack,
    input logic lo_gate,
    input logic hs_inhibit,
    input logic mon_window,
    input logic oc_trip
);
    // Independent run-length of the low-side command
    logic [15:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!lo_gate) begin
            run_q <= '0;
        end else if (run_q != 16'hFFFF) begin
            run_q <= run_q + 1'b1;
        end
    end

    assert_window_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_gate |-> !mon_window);

    assert_inhibit_needs_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hs_inhibit |-> lo_gate);

    assert_window_after_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mon_window |-> (run_q >= 16'(BLANK_CYC)));

    assert_window_opens_on_time_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mon_window) |-> (run_q == 16'(BLANK_CYC)));

    assert_trip_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oc_trip) |-> ($past(mon_window) && $past(oc_raw)));

    assert_trip_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(oc_trip) && !$past(cyc_strobe) && !$past(oc_ack)) |-> oc_trip);

    assert_rise_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_gate) |-> ($past(pwm_lo_req) || $past(cyc_strobe)));

    assert_forced_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lo_gate) && $past(hs_inhibit)) |-> ($past(run_q) == 16'(MIN_CYC - 1)));

endmodule

bind lowside_pulse_guard lowside_pulse_guard_chk #(
    .BLANK_CYC (BLANK_CYC),
    .MIN_CYC   (MIN_CYC)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_strobe (cyc_strobe),
    .pwm_lo_req (pwm_lo_req),
    .oc_raw     (oc_raw),
    .oc_ack     (oc_ack),
    .lo_gate    (lo_gate),
    .hs_inhibit (hs_inhibit),
    .mon_window (mon_window),
    .oc_trip    (oc_trip)
);

// File: tb/test_lowside_pulse_guard.sv
module test_lowside_pulse_guard;

    localparam int BLANK = 25;
    localparam int MINW  = 53;
    localparam int PER   = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_strobe = 1'b0;
    logic pwm_lo_req = 1'b0;
    logic oc_raw = 1'b0;
    logic oc_ack = 1'b0;
    logic lo_gate, hs_inhibit, mon_window, oc_trip;

    always #4 clk = ~clk;

    lowside_pulse_guard #(.BLANK_CYC(BLANK), .MIN_CYC(MINW), .RUN_LEN(3)) i_lowside_pulse_guard (
        .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .pwm_lo_req(pwm_lo_req),
        .oc_raw(oc_raw), .oc_ack(oc_ack), .lo_gate(lo_gate), .hs_inhibit(hs_inhibit),
        .mon_window(mon_window), .oc_trip(oc_trip)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Behavioural reference: integer bookkeeping of on-time, forcing and run count
    int m_on, m_hold, m_w, m_fl, m_runs, m_wide, m_seen, m_trip;

    // Pulse monitor
    int widths[$];
    int hsflag[$];
    int cur_w, cur_hs;
    int pr_lo, pr_win, pr_hs, pr_trip;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_on = 0; m_hold = 0; m_w = 0; m_fl = 0;
        m_runs = 0; m_wide = 0; m_seen = 0; m_trip = 0;
    endtask

    task automatic model_step(int pwm, int strb, int oc, int ack);
        int armed, sok, ins, win, hit, whit;
        int n_on, n_hold, n_w, n_fl;
        armed = (m_runs == 2);
        sok   = armed || m_fl;
        ins   = strb && armed && !m_seen && !m_on;
        win   = m_on && (m_w >= BLANK);
        hit   = win && oc;
        whit  = m_on && (m_w == MINW - 1);
        if (!m_on) begin
            if (pwm != 0) begin n_on = 1; n_hold = 0; end
            else if (ins != 0) begin n_on = 1; n_hold = 1; end
            else begin n_on = 0; n_hold = 0; end
        end else if (m_hold != 0) begin
            if (m_w + 1 >= MINW) begin n_on = pwm; n_hold = 0; end
            else begin n_on = 1; n_hold = 1; end
        end else if (pwm == 0) begin
            if (sok && (m_w + 1 < MINW)) begin n_on = 1; n_hold = 1; end
            else begin n_on = 0; n_hold = 0; end
        end else begin
            n_on = 1; n_hold = 0;
        end
        n_w  = (!m_on || !n_on) ? 0 : ((m_w + 1 > MINW) ? MINW : m_w + 1);
        n_fl = n_on ? (m_fl || armed || ins) : 0;
        if (strb != 0) begin
            m_runs = (m_wide || armed) ? 0 : m_runs + 1;
            m_wide = whit;
            m_seen = 0;
        end else begin
            m_wide = m_wide || whit;
            m_seen = m_seen || m_on;
        end
        if (hit != 0) m_trip = 1;
        else if (strb != 0 || ack != 0) m_trip = 0;
        m_on = n_on; m_hold = n_hold; m_w = n_w; m_fl = n_fl;
    endtask

    task automatic compare_all();
        chk("R2 lo_gate", int'(lo_gate), m_on);
        chk("R3 mon_window", int'(mon_window), (m_on != 0 && m_w >= BLANK) ? 1 : 0);
        chk("R8 hs_inhibit", int'(hs_inhibit), m_hold);
        chk("R6 oc_trip", int'(oc_trip), m_trip);
    endtask

    task automatic monitor();
        if (lo_gate) begin
            cur_w++;
            if (hs_inhibit) cur_hs = 1;
        end else if (cur_w > 0) begin
            widths.push_back(cur_w);
            hsflag.push_back(cur_hs);
            cur_w = 0;
            cur_hs = 0;
        end
    endtask

    // One clock: drive at negedge, advance model, compare at next negedge
    task automatic tick(int pwm, int strb, int oc, int ack);
        pwm_lo_req = pwm[0];
        cyc_strobe = strb[0];
        oc_raw     = oc[0];
        oc_ack     = ack[0];
        model_step(pwm, strb, oc, ack);
        @(negedge clk);
        compare_all();
        monitor();
    endtask

    task automatic run_cycle(int st, int len, int oc_t, int ack_t, int probe_t);
        widths.delete();
        hsflag.delete();
        for (int t = 0; t < PER; t++) begin
            tick((t >= st && t < st + len) ? 1 : 0, (t == 0) ? 1 : 0,
                 (t == oc_t) ? 1 : 0, (t == ack_t) ? 1 : 0);
            if (t == probe_t) begin
                pr_lo = lo_gate; pr_win = mon_window; pr_hs = hs_inhibit; pr_trip = oc_trip;
            end
        end
    endtask

    function automatic int first_w();
        return (widths.size() > 0) ? widths[0] : -1;
    endfunction

    function automatic int first_hs();
        return (hsflag.size() > 0) ? hsflag[0] : -1;
    endfunction

    initial begin
        int tripped;
        model_reset();
        cur_w = 0; cur_hs = 0;
        repeat (4) @(negedge clk);
        // R1: outputs idle during reset
        chk("R1 lo_gate in reset", int'(lo_gate), 0);
        chk("R1 hs_inhibit in reset", int'(hs_inhibit), 0);
        chk("R1 mon_window in reset", int'(mon_window), 0);
        chk("R1 oc_trip in reset", int'(oc_trip), 0);
        rst_n = 1'b1;
        tick(0, 0, 0, 0);
        chk("R1 lo_gate after reset", int'(lo_gate), 0);

        // R2 / R9: wide pulses pass unchanged
        run_cycle(100, 80, -1, -1, -1);
        run_cycle(100, 80, -1, -1, -1);
        chk("R2 wide pulse width", first_w(), 80);
        chk("R2 wide pulse not forced", first_hs(), 0);

        // R5: comparator during blanking and with the low side off
        run_cycle(100, 80, 110, -1, 199);
        chk("R5 trip ignored in blank", pr_trip, 0);
        run_cycle(100, 80, 190, -1, 199);
        chk("R5 trip ignored while off", pr_trip, 0);

        // R6: qualified trip, cleared by strobe, cleared by ack
        run_cycle(100, 80, 140, -1, 199);
        chk("R6 trip held to cycle end", pr_trip, 1);
        run_cycle(100, 80, -1, -1, 0);
        chk("R6 trip cleared by strobe", pr_trip, 0);
        run_cycle(100, 80, 140, -1, 160);
        chk("R6 trip set inside window", pr_trip, 1);
        run_cycle(100, 80, 140, 170, 171);
        chk("R6 trip cleared by ack", pr_trip, 0);

        // R3: window opening edge
        run_cycle(100, 80, -1, -1, 124);
        chk("R3 window shut in blank", pr_win, 0);
        run_cycle(100, 80, -1, -1, 125);
        chk("R3 window open after blank", pr_win, 1);

        // R4: window closes as the low side falls
        run_cycle(100, 80, -1, -1, 179);
        chk("R4 window open at last on clock", pr_win, 1);
        run_cycle(100, 80, -1, -1, 180);
        chk("R4 lo_gate off", pr_lo, 0);
        chk("R4 window closed with lo_gate", pr_win, 0);

        // R7: third narrow pulse stretched
        run_cycle(100, 10, -1, -1, -1);
        chk("R7 first narrow kept", first_w(), 10);
        run_cycle(100, 10, -1, -1, -1);
        chk("R7 second narrow kept", first_w(), 10);
        run_cycle(100, 10, -1, -1, 130);
        chk("R7 third narrow stretched", first_w(), MINW);
        chk("R7 stretch raises hs_inhibit", first_hs(), 1);
        chk("R7 hs_inhibit during hold", pr_hs, 1);

        // R10: forcing recurs every third cycle
        run_cycle(100, 10, -1, -1, -1);
        chk("R10 count restarted after stretch", first_w(), 10);
        run_cycle(100, 10, -1, -1, -1);
        chk("R10 second narrow kept", first_w(), 10);
        run_cycle(100, 10, -1, -1, -1);
        chk("R10 next third narrow stretched", first_w(), MINW);

        // R8: three empty cycles, insertion at the closing strobe
        run_cycle(0, 0, -1, -1, -1);
        run_cycle(0, 0, -1, -1, -1);
        run_cycle(0, 0, -1, -1, -1);
        chk("R8 no pulse yet in empty cycles", int'(widths.size()), 0);
        run_cycle(100, 80, -1, -1, 0);
        chk("R8 inserted pulse starts after strobe", pr_lo, 1);
        chk("R8 inserted pulse width", first_w(), MINW);
        chk("R8 inserted pulse inhibits high side", first_hs(), 1);
        chk("R8 request pulse follows", (widths.size() > 1) ? widths[1] : -1, 80);

        // R9: a wide pulse resets the narrow run
        run_cycle(100, 10, -1, -1, -1);
        run_cycle(100, 80, -1, -1, -1);
        run_cycle(100, 10, -1, -1, -1);
        chk("R9 narrow after reset kept", first_w(), 10);
        run_cycle(100, 10, -1, -1, -1);
        chk("R9 second narrow after reset kept", first_w(), 10);
        chk("R9 no forcing after reset", first_hs(), 0);

        // R5 again with narrow pulses: oc inside a short pulse never qualifies
        tripped = 0;
        widths.delete();
        for (int t = 0; t < PER; t++) begin
            tick((t >= 100 && t < 110) ? 1 : 0, (t == 0) ? 1 : 0, (t >= 100 && t < 112) ? 1 : 0, 0);
            if (oc_trip) tripped = 1;
        end
        chk("R5 comparator in blanked narrow pulse", tripped, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int n = 0; n < 150000; n++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule